// File: doc/BRIEF.md
# Integer Status Flag Unit

This block sits beside an integer datapath. It takes two operands of a configurable width (8, 16 or 32 bits) and a three-bit operation code. In the same cycle it forms the result of an add, subtract, compare, bitwise AND, OR, XOR or test. It also raises a strobe that tells the register file whether the result should be written back. Six status bits are derived from that result and its operands: carry/borrow, signed overflow, zero, sign, low-byte parity and nibble carry/borrow.

The status bits are captured in a flag register on the rising clock edge. This happens only while the flag write enable is high and the operation code is one of the seven defined codes. Compare and test exist only to set flags. For these codes the result bus still shows the difference or the AND, but the write-back strobe stays low. Downstream branch logic reads the registered flags.

Top module: `status_flag_unit`

## Requirements
- R1: For code 0 (add) the result is (a + b) mod 2^W, and the carry flag (flags bit 0) is set exactly when the true sum is 2^W or more (for example 0xFF + 0x01 gives 0x00 with carry set).
- R2: For codes 1 (subtract) and 2 (compare) the result is (a - b) mod 2^W, and the carry flag is set exactly when a < b as unsigned numbers (for example 0x00 - 0x01 gives 0xFF with carry set).
- R3: The overflow flag (flags bit 5) is set on add when both operands have the same sign bit and the result's sign bit differs. On subtract and compare it is set when the operand signs differ and the result's sign differs from that of a.
- R4: The zero flag (flags bit 3) is set exactly when every result bit is zero.
- R5: The sign flag (flags bit 4) equals the most significant bit of the result.
- R6: The parity flag (flags bit 1) is set when result bits 7:0 hold an even number of ones, whatever the width W.
- R7: The nibble flag (flags bit 2) is set on add when bits 3:0 of a and b carry into bit 4. On subtract and compare it is set when a[3:0] < b[3:0].
- R8: For codes 3 (AND), 4 (OR), 5 (XOR) and 6 (test, an AND) the result is the bitwise operation. The write-back strobe is high for codes 0, 1, 3, 4 and 5 and low for codes 2 and 6.
- R9: For codes 3 to 6 the carry, overflow and nibble flags are loaded as zero.
- R10: With reset high the flag register clears to zero on the clock edge. Otherwise it loads all six flags when flag_we is high and holds them when it is low.
- R11: Code 7 is reserved. It gives a zero result and a low strobe, and it leaves the flag register unchanged even with flag_we high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 and, 4 or, 5 xor, 6 test, 7 reserved) |
| opa | input | WIDTH | First operand (minuend for subtract/compare) |
| opb | input | WIDTH | Second operand |
| flag_we | input | 1 | Flag register write enable |
| result | output | WIDTH | Combinational operation result |
| result_we | output | 1 | Result write-back strobe, combinational |
| flags_q | output | 6 | Registered flags {overflow, sign, zero, nibble, parity, carry} |

## Verification
The result and the write-back strobe are combinational. The bench checks them in the same cycle the operands are driven, one nanosecond after the falling edge at which they change. The flags pass through one register, so their expected value is due just after the following rising edge. The bench's reference model commits its own flag state at that edge, under the same enable, reserved-code and reset rules, and compares all six bits one nanosecond later. Each bit is compared under the tag of the requirement that governs it for the operation in flight.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    localparam int FLAG_BITS = 6;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_TEST = 3'd6,
        OP_NONE = 3'd7
    } sfu_op_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic nibble;
        logic parity;
        logic carry;
    } sfu_flags_t;

endpackage

// File: rtl/sfu_addsub.sv
module sfu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_flag,
    output logic             ovf_flag,
    output logic             nibble_flag
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;
    logic [4:0]       low;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        low   = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0000, sub};
        sum   = full[MSB:0];
        // a subtract is a + ~b + 1: no carry out means a borrow
        carry_flag  = sub ? ~full[WIDTH] : full[WIDTH];
        nibble_flag = sub ? ~low[4] : low[4];
        ovf_flag    = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
    end

endmodule

// File: rtl/sfu_logic.sv
module sfu_logic #(
    parameter int WIDTH = 8
) (
    input  sfu_pkg::sfu_op_e op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res
);
    import sfu_pkg::*;

    always_comb begin
        unique case (op)
            OP_AND, OP_TEST: res = a & b;
            OP_OR:           res = a | b;
            OP_XOR:          res = a ^ b;
            default:         res = '0;
        endcase
    end

endmodule

// File: rtl/sfu_flag_reg.sv
module sfu_flag_reg (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  sfu_pkg::sfu_flags_t d,
    output sfu_pkg::sfu_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             flag_we,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic [5:0]       flags_q
);
    import sfu_pkg::*;

    localparam int MSB = WIDTH - 1;

    sfu_op_e          op;
    logic             is_sub;
    logic             is_arith;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic             a_carry;
    logic             a_ovf;
    logic             a_nib;
    sfu_flags_t       flags_d;
    sfu_flags_t       flags_r;
    logic             load;

    assign op     = sfu_op_e'(op_sel);
    assign is_sub = (op == OP_SUB) || (op == OP_CMP);

    sfu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a           (opa),
        .b           (opb),
        .sub         (is_sub),
        .sum         (arith_res),
        .carry_flag  (a_carry),
        .ovf_flag    (a_ovf),
        .nibble_flag (a_nib)
    );

    sfu_logic #(.WIDTH(WIDTH)) u_logic (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .res (logic_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_CMP: begin
                result    = arith_res;
                is_arith  = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_TEST: begin
                result    = logic_res;
                is_arith  = 1'b0;
            end
            default: begin
                result    = '0;
                is_arith  = 1'b0;
            end
        endcase
    end

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: result_we = 1'b1;
            default:                               result_we = 1'b0;
        endcase
    end

    always_comb begin
        flags_d.carry  = is_arith & a_carry;
        flags_d.ovf    = is_arith & a_ovf;
        flags_d.nibble = is_arith & a_nib;
        flags_d.zero   = (result == '0);
        flags_d.sign   = result[MSB];
        flags_d.parity = ~^result[7:0];
    end

    assign load = flag_we && (op != OP_NONE);

    sfu_flag_reg u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (flags_d),
        .q    (flags_r)
    );

    assign flags_q = flags_r;

endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             flag_we,
    input logic [WIDTH-1:0] result,
    input logic             result_we,
    input logic [5:0]       flags_q
);
    localparam int MSB = WIDTH - 1;

    logic defined_op;
    logic logic_op;
    assign defined_op = (op_sel != 3'd7);
    assign logic_op   = (op_sel >= 3'd3) && (op_sel <= 3'd6);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (flags_q == 6'd0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags_q));

    assert_reserved_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd7) |=> $stable(flags_q));

    assert_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        ((op_sel == 3'd2) || (op_sel == 3'd6)) |-> !result_we);

    assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_we && defined_op) |=> (flags_q[3] == ($past(result) == '0)));

    assert_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_we && defined_op) |=> (flags_q[4] == $past(result[MSB])));

    assert_logic_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_we && logic_op) |=> (flags_q[0] == 1'b0 && flags_q[2] == 1'b0 && flags_q[5] == 1'b0));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_sel == 3'd0 && opa[MSB] == opb[MSB] && result[MSB] == opa[MSB])
        |=> !flags_q[5]);

endmodule

bind status_flag_unit sfu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_sel    (op_sel),
    .opa       (opa),
    .opb       (opb),
    .flag_we   (flag_we),
    .result    (result),
    .result_we (result_we),
    .flags_q   (flags_q)
);

// File: tb/status_flag_unit_test.sv
`timescale 1ns/1ps
module status_flag_unit_test;

    localparam int W = 8;
    localparam longint MASK = (64'd1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op_sel = 3'd7;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         flag_we = 1'b0;
    logic [W-1:0] result;
    logic         result_we;
    logic [5:0]   flags_q;

    int vectors = 0;
    int miscompares = 0;
    bit [5:0] exp_flags = '0;

    always #5 clk = ~clk;

    status_flag_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
        .flag_we(flag_we), .result(result), .result_we(result_we), .flags_q(flags_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference: wide integer arithmetic
    task automatic model(input int op, input longint a, input longint b,
                         output longint res, output bit we, output bit [5:0] f);
        longint full;
        bit cf, of, af, sa, sb, sr;
        cf = 0; of = 0; af = 0; res = 0;
        sa = a[W-1]; sb = b[W-1];
        case (op)
            0: begin
                full = a + b; res = full & MASK; cf = (full > MASK);
                af = ((a & 15) + (b & 15)) > 15;
                sr = res[W-1]; of = (sa == sb) && (sr != sa);
            end
            1, 2: begin
                res = (a - b) & MASK; cf = (a < b); af = ((a & 15) < (b & 15));
                sr = res[W-1]; of = (sa != sb) && (sr != sa);
            end
            3, 6: res = a & b;
            4: res = a | b;
            5: res = a ^ b;
            default: res = 0;
        endcase
        we = (op == 0) || (op == 1) || (op == 3) || (op == 4) || (op == 5);
        f[0] = cf;
        f[1] = ($countones(res[7:0]) % 2) == 0;
        f[2] = af;
        f[3] = (res == 0);
        f[4] = res[W-1];
        f[5] = of;
    endtask

    function automatic string flag_tag(input int bitn, input int op, input bit we);
        if (!we) return "R10";
        if (op == 7) return "R11";
        case (bitn)
            0: return (op == 0) ? "R1" : (op <= 2) ? "R2" : "R9";
            1: return "R6";
            2: return (op <= 2) ? "R7" : "R9";
            3: return "R4";
            4: return "R5";
            default: return (op <= 2) ? "R3" : "R9";
        endcase
    endfunction

    task automatic step(input int op, input longint a, input longint b, input bit we);
        longint er; bit ew; bit [5:0] ef;
        string rtag;
        @(negedge clk);
        op_sel = op[2:0]; opa = a[W-1:0]; opb = b[W-1:0]; flag_we = we;
        #1;
        model(op, a & MASK, b & MASK, er, ew, ef);
        rtag = (op == 0) ? "R1" : (op == 1 || op == 2) ? "R2" : (op == 7) ? "R11" : "R8";
        chk(rtag, {56'd0, result}, er);
        chk((op == 7) ? "R11" : "R8", {63'd0, result_we}, {63'd0, ew});
        @(posedge clk);
        if (we && op != 7) exp_flags = ef;
        #1;
        for (int i = 0; i < 6; i++)
            chk(flag_tag(i, op, we), {63'd0, flags_q[i]}, {63'd0, exp_flags[i]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R10 reset", {58'd0, flags_q}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        step(0, 'hFF, 'h01, 1);   // R1 carry out, zero result
        step(1, 'h00, 'h01, 1);   // R2 borrow
        step(0, 'h40, 'h40, 1);   // R3 positive overflow
        step(0, 'h80, 'h80, 1);   // R3 negative overflow
        step(0, 'hC0, 'hC0, 1);   // R3 no overflow
        step(0, 'h60, 'h90, 1);   // R3 mixed signs
        step(1, 'h80, 'h01, 1);   // R3 subtract overflow
        step(0, 'h1A, 'h01, 1);   // R6 even parity
        step(0, 'h18, 'h01, 1);   // R6 odd parity
        step(0, 'h0F, 'h01, 1);   // R7 nibble carry
        step(1, 'h10, 'h01, 1);   // R7 nibble borrow
        step(2, 'h05, 'h05, 1);   // R8 compare: zero, no strobe
        step(6, 'hF0, 'h0F, 1);   // R8 test: no strobe
        step(0, 'hFF, 'hFF, 1);   // set carry/nibble before logic op
        step(3, 'hF3, 'h8F, 1);   // R9 AND clears carry
        step(4, 'h80, 'h01, 1);   // R9 OR
        step(5, 'hAA, 'hAA, 1);   // R9 XOR zero
        step(0, 'hFF, 'h01, 0);   // R10 hold with flag_we low
        step(7, 'h12, 'h34, 1);   // R11 reserved code
        step(0, 'h7F, 'h01, 1);
        @(negedge clk); rst = 1'b1; op_sel = 3'd0; flag_we = 1'b1;
        @(posedge clk); exp_flags = '0; #1;
        chk("R10 sync reset", {58'd0, flags_q}, 64'd0);
        @(negedge clk); rst = 1'b0;

        for (int n = 0; n < 400; n++)
            step(int'($urandom_range(0, 7)), longint'($urandom) & MASK,
                 longint'($urandom) & MASK, ($urandom_range(0, 3) != 0));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule